// File: doc/BRIEF.md
# Three-Byte Instruction Window Cache

This block is an instruction-fetch cache for a small 8-bit processor that works with a 28-bit physical address. Each entry stores the three bytes that begin at one byte address. A hit therefore returns the opcode and both operand bytes in the same cycle as the lookup. The lookup path is purely combinational from the lookup address to the hit flag and the instruction word. After a miss, the surrounding logic fetches the three bytes and writes them in through the fill port.

Storage is split into four sub-caches. The two lowest address bits pick the sub-cache, the next eight bits pick a set, and each set holds four ways. When the processor or a DMA engine writes a byte, the snoop port drops every entry whose window could contain that byte. Those are the windows that start at A, A-1 and A-2. The three targets always fall in different sub-caches, so all of them are cleared in the same cycle. The clear covers every way of each target set and does not compare tags. On a fill that does not refresh an existing entry, the victim way is chosen by a free-running pseudo-random register.

Top module: `icache_top`

## Requirements
- R1: When a valid entry in the addressed set matches the lookup tag, `hit_o` is 1 and `instr_o` returns the stored bytes in the same cycle, with no clock edge in between. `instr_o[7:0]` is the byte at the lookup address, `[15:8]` the byte at address+1 and `[23:16]` the byte at address+2.
- R2: On a miss, `hit_o` is 0 and `instr_o` is zero.
- R3: Address bits [1:0] select the sub-cache, bits [9:2] select the set and bits [27:10] form the stored tag. Up to four addresses that share bits [9:0] but have different tags can be held at the same time.
- R4: A fill whose tag already sits in a valid way of its set overwrites that way. Any other fill writes the way numbered by the low two bits of the pseudo-random register.
- R5: The pseudo-random register is 8 bits wide and loads 0x01 on reset. On every clock edge outside reset it shifts left by one bit, and the new bit 0 is the XOR of the old bits 7, 5, 4 and 3. A fill on an edge uses the value held before that edge.
- R6: A snoop write to byte A clears all four ways of the sets that hold windows A, A-1 and A-2, whatever their tags, on a single clock edge.
- R7: The target arithmetic is modulo 2^28. At a 4-byte boundary, A-1 and A-2 fall in the previous set index, and a write to address 0 clears the windows at 0x FFFFFFF and 0xFFFFFFE.
- R8: If a fill and a snoop write in the same cycle target the same sub-cache and set, the invalidation wins and the fill is dropped.
- R9: A synchronous reset clears every valid bit, so no lookup hits until a new fill.
- R10: Fills and invalidations take effect on the clock edge. A lookup made in the same cycle sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| lookup_addr_i | input | 28 | Byte address of the instruction to look up |
| hit_o | output | 1 | Lookup hit (combinational) |
| instr_o | output | 24 | Three instruction bytes, lowest address in the low byte |
| fill_valid_i | input | 1 | Write a fetched window into the cache |
| fill_addr_i | input | 28 | Start address of the window being filled |
| fill_data_i | input | 24 | Window bytes, same byte order as `instr_o` |
| snoop_we_i | input | 1 | A memory byte write happened |
| snoop_addr_i | input | 28 | Byte address of that write |

## Verification
The bench goes after four corner cases:
- Snoop writes at a 4-byte boundary and at address zero. An index calculation that fails to borrow into the set field, or that fails to wrap the 28-bit address, would clear the wrong set and leave a stale window that still hits.
- Fills of five different tags into one set, followed by refills of a tag that is already present. Here victim selection has to follow the pseudo-random sequence exactly, and a refill must not create a duplicate way.
- A fill and a colliding snoop in the same cycle. A design that lets the fill win would return stale bytes on the next lookup.
- A long random run over a few sets with mixed tags, compared on every clock. This checks that snoops clear ways whose tags differ from the written address.

// File: rtl/icache_pkg.sv
package icache_pkg;

   // Width of the free-running victim selector
   localparam int RND_W = 8;
   localparam logic [RND_W-1:0] RND_SEED = 8'h01;

   // One step of the selector: shift left, feedback from bits 7,5,4,3
   function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
      return {s[RND_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

endpackage

// File: rtl/icache_rnd.sv
module icache_rnd
   import icache_pkg::*;
#(
   parameter int OUT_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [OUT_W-1:0] pick_o
);

   logic [RND_W-1:0] state_q;

   if (OUT_W > RND_W) begin : g_bad_width
      $error("icache_rnd: OUT_W exceeds selector width");
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= RND_SEED;
      else       state_q <= rnd_step(state_q);
   end

   assign pick_o = state_q[OUT_W-1:0];

endmodule

// File: rtl/icache_snoop_map.sv
module icache_snoop_map #(
   parameter int ADDR_W     = 28,
   parameter int BANK_BITS  = 2,
   parameter int SET_BITS   = 8,
   parameter int LINE_BYTES = 3
) (
   input  logic                             we_i,
   input  logic [ADDR_W-1:0]                addr_i,
   output logic [(1<<BANK_BITS)-1:0]        clr_en_o,
   output logic [(1<<BANK_BITS)-1:0][SET_BITS-1:0] clr_set_o
);

   localparam int NBANK = 1 << BANK_BITS;

   logic [LINE_BYTES-1:0][ADDR_W-1:0] tgt;

   // Window start addresses that may contain the written byte
   for (genvar k = 0; k < LINE_BYTES; k++) begin : g_tgt
      assign tgt[k] = addr_i - ADDR_W'(k);
   end

   // Targets always land in distinct banks (LINE_BYTES <= NBANK)
   always_comb begin
      clr_en_o  = '0;
      clr_set_o = '0;
      for (int k = 0; k < LINE_BYTES; k++) begin
         if (we_i) begin
            clr_en_o[tgt[k][BANK_BITS-1:0]]  = 1'b1;
            clr_set_o[tgt[k][BANK_BITS-1:0]] = tgt[k][BANK_BITS +: SET_BITS];
         end
      end
   end

   if (NBANK < LINE_BYTES) begin : g_bad_banks
      $error("icache_snoop_map: fewer banks than window bytes");
   end

endmodule

// File: rtl/icache_bank.sv
module icache_bank #(
   parameter int SET_BITS = 8,
   parameter int WAYS     = 4,
   parameter int TAG_W    = 18,
   parameter int DATA_W   = 24,
   localparam int WAY_BITS = $clog2(WAYS)
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [SET_BITS-1:0] lk_set_i,
   input  logic [TAG_W-1:0]    lk_tag_i,
   output logic                lk_hit_o,
   output logic [DATA_W-1:0]   lk_data_o,
   input  logic                fill_en_i,
   input  logic [SET_BITS-1:0] fill_set_i,
   input  logic [TAG_W-1:0]    fill_tag_i,
   input  logic [DATA_W-1:0]   fill_data_i,
   input  logic [WAY_BITS-1:0] victim_i,
   input  logic                clr_en_i,
   input  logic [SET_BITS-1:0] clr_set_i
);

   localparam int SETS = 1 << SET_BITS;

   logic [WAYS-1:0]   vld_q [SETS];
   logic [TAG_W-1:0]  tag_q [SETS][WAYS];
   logic [DATA_W-1:0] dat_q [SETS][WAYS];

   logic [WAY_BITS-1:0] fill_way;
   logic                fill_ok;

   // Lookup: descending scan so the lowest matching way wins
   always_comb begin
      lk_hit_o  = 1'b0;
      lk_data_o = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (vld_q[lk_set_i][w] && tag_q[lk_set_i][w] == lk_tag_i) begin
            lk_hit_o  = 1'b1;
            lk_data_o = dat_q[lk_set_i][w];
         end
      end
   end

   // Refresh an existing way, otherwise take the random victim
   always_comb begin
      fill_way = victim_i;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (vld_q[fill_set_i][w] && tag_q[fill_set_i][w] == fill_tag_i)
            fill_way = WAY_BITS'(w);
      end
   end

   // Invalidation of the same set suppresses the fill
   assign fill_ok = fill_en_i && !(clr_en_i && clr_set_i == fill_set_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
         if (fill_ok)  vld_q[fill_set_i][fill_way] <= 1'b1;
         if (clr_en_i) vld_q[clr_set_i] <= '0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (fill_ok) begin
         tag_q[fill_set_i][fill_way] <= fill_tag_i;
         dat_q[fill_set_i][fill_way] <= fill_data_i;
      end
   end

endmodule

// File: rtl/icache_top.sv
module icache_top #(
   parameter int ADDR_W     = 28,
   parameter int BANK_BITS  = 2,
   parameter int SET_BITS   = 8,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 3,
   localparam int DATA_W    = 8 * LINE_BYTES
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] lookup_addr_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] instr_o,
   input  logic              fill_valid_i,
   input  logic [ADDR_W-1:0] fill_addr_i,
   input  logic [DATA_W-1:0] fill_data_i,
   input  logic              snoop_we_i,
   input  logic [ADDR_W-1:0] snoop_addr_i
);

   localparam int NBANK    = 1 << BANK_BITS;
   localparam int IDX_W    = BANK_BITS + SET_BITS;
   localparam int TAG_W    = ADDR_W - IDX_W;
   localparam int WAY_BITS = $clog2(WAYS);

   // Elaboration-time parameter checks
   if (TAG_W < 1) begin : g_chk_tag
      $error("icache_top: address too narrow for index");
   end
   if (WAYS < 2 || (1 << WAY_BITS) != WAYS) begin : g_chk_ways
      $error("icache_top: WAYS must be a power of two >= 2");
   end
   if (LINE_BYTES < 1 || LINE_BYTES > NBANK) begin : g_chk_line
      $error("icache_top: LINE_BYTES must fit the bank count");
   end

   logic [WAY_BITS-1:0]                 victim;
   logic [NBANK-1:0]                    clr_en;
   logic [NBANK-1:0][SET_BITS-1:0]      clr_set;
   logic [NBANK-1:0]                    bank_hit;
   logic [NBANK-1:0][DATA_W-1:0]        bank_data;

   logic [BANK_BITS-1:0] lk_bank, fill_bank;
   logic [SET_BITS-1:0]  lk_set, fill_set;
   logic [TAG_W-1:0]     lk_tag, fill_tag;

   assign lk_bank   = lookup_addr_i[BANK_BITS-1:0];
   assign lk_set    = lookup_addr_i[BANK_BITS +: SET_BITS];
   assign lk_tag    = lookup_addr_i[ADDR_W-1:IDX_W];
   assign fill_bank = fill_addr_i[BANK_BITS-1:0];
   assign fill_set  = fill_addr_i[BANK_BITS +: SET_BITS];
   assign fill_tag  = fill_addr_i[ADDR_W-1:IDX_W];

   icache_rnd #(.OUT_W(WAY_BITS)) rnd_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .pick_o (victim)
   );

   icache_snoop_map #(
      .ADDR_W     (ADDR_W),
      .BANK_BITS  (BANK_BITS),
      .SET_BITS   (SET_BITS),
      .LINE_BYTES (LINE_BYTES)
   ) snoop_i (
      .we_i      (snoop_we_i),
      .addr_i    (snoop_addr_i),
      .clr_en_o  (clr_en),
      .clr_set_o (clr_set)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      icache_bank #(
         .SET_BITS (SET_BITS),
         .WAYS     (WAYS),
         .TAG_W    (TAG_W),
         .DATA_W   (DATA_W)
      ) bank_i (
         .clk_i       (clk_i),
         .rst_i       (rst_i),
         .lk_set_i    (lk_set),
         .lk_tag_i    (lk_tag),
         .lk_hit_o    (bank_hit[b]),
         .lk_data_o   (bank_data[b]),
         .fill_en_i   (fill_valid_i && fill_bank == BANK_BITS'(b)),
         .fill_set_i  (fill_set),
         .fill_tag_i  (fill_tag),
         .fill_data_i (fill_data_i),
         .victim_i    (victim),
         .clr_en_i    (clr_en[b]),
         .clr_set_i   (clr_set[b])
      );
   end

   assign hit_o   = bank_hit[lk_bank];
   assign instr_o = bank_data[lk_bank];

endmodule

// File: rtl/icache_checker.sv
module icache_checker #(
   parameter int ADDR_W = 28,
   parameter int DATA_W = 24
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [ADDR_W-1:0] lookup_addr_i,
   input logic              hit_o,
   input logic [DATA_W-1:0] instr_o,
   input logic              fill_valid_i,
   input logic [ADDR_W-1:0] fill_addr_i,
   input logic [DATA_W-1:0] fill_data_i,
   input logic              snoop_we_i,
   input logic [ADDR_W-1:0] snoop_addr_i
);

   // R2: a miss drives no data
   assert_miss_quiet_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !hit_o |-> instr_o == '0);

   // R9: nothing hits in the first cycle after reset
   assert_reset_empty_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> !hit_o);

   // R1, R10: a fill without a snoop is visible on the next cycle
   assert_fill_visible_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(fill_valid_i && !snoop_we_i && !rst_i) && lookup_addr_i == $past(fill_addr_i))
      |-> (hit_o && instr_o == $past(fill_data_i)));

   // R6, R7, R8: windows A, A-1, A-2 miss after a snoop
   assert_snoop_clears_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(snoop_we_i && !rst_i) &&
       (lookup_addr_i == $past(snoop_addr_i) ||
        lookup_addr_i == $past(snoop_addr_i) - ADDR_W'(1) ||
        lookup_addr_i == $past(snoop_addr_i) - ADDR_W'(2)))
      |-> !hit_o);

   // R1: hit flag is always a defined value
   assert_hit_known_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      !$isunknown(hit_o));

endmodule

bind icache_top icache_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .lookup_addr_i (lookup_addr_i),
   .hit_o         (hit_o),
   .instr_o       (instr_o),
   .fill_valid_i  (fill_valid_i),
   .fill_addr_i   (fill_addr_i),
   .fill_data_i   (fill_data_i),
   .snoop_we_i    (snoop_we_i),
   .snoop_addr_i  (snoop_addr_i)
);

// File: tb/icache_top_tb_top.sv
module icache_top_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic [27:0] lookup_addr, fill_addr, snoop_addr;
   logic        fill_valid, snoop_we;
   logic [23:0] fill_data;
   logic        hit;
   logic [23:0] instr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   icache_top dut_i (
      .clk_i         (clk),
      .rst_i         (rst),
      .lookup_addr_i (lookup_addr),
      .hit_o         (hit),
      .instr_o       (instr),
      .fill_valid_i  (fill_valid),
      .fill_addr_i   (fill_addr),
      .fill_data_i   (fill_data),
      .snoop_we_i    (snoop_we),
      .snoop_addr_i  (snoop_addr)
   );

   // Behavioural reference: per (bank,set,way) entries plus the selector
   bit        m_v [4][256][4];
   int        m_t [4][256][4];
   int        m_d [4][256][4];
   bit [7:0]  m_rnd;

   function automatic void m_lookup(input bit [27:0] a, output bit h, output bit [23:0] d);
      h = 0; d = 0;
      for (int w = 0; w < 4; w++)
         if (!h && m_v[a[1:0]][a[9:2]][w] && m_t[a[1:0]][a[9:2]][w] == int'(a[27:10])) begin
            h = 1; d = 24'(m_d[a[1:0]][a[9:2]][w]);
         end
   endfunction

   function automatic void m_edge(input bit r, input bit fv, input bit [27:0] fa,
                                  input bit [23:0] fd, input bit sw, input bit [27:0] sa);
      if (r) begin
         for (int b = 0; b < 4; b++)
            for (int s = 0; s < 256; s++)
               for (int w = 0; w < 4; w++) m_v[b][s][w] = 0;
         m_rnd = 8'h01;
         return;
      end
      if (fv) begin
         bit blocked = 0;
         int way = int'(m_rnd[1:0]);
         for (int k = 0; k < 3; k++) begin
            bit [27:0] t = sa - 28'(k);
            if (sw && t[9:0] == fa[9:0]) blocked = 1;
         end
         for (int w = 3; w >= 0; w--)
            if (m_v[fa[1:0]][fa[9:2]][w] && m_t[fa[1:0]][fa[9:2]][w] == int'(fa[27:10])) way = w;
         if (!blocked) begin
            m_v[fa[1:0]][fa[9:2]][way] = 1;
            m_t[fa[1:0]][fa[9:2]][way] = int'(fa[27:10]);
            m_d[fa[1:0]][fa[9:2]][way] = int'(fd);
         end
      end
      if (sw)
         for (int k = 0; k < 3; k++) begin
            bit [27:0] t = sa - 28'(k);
            for (int w = 0; w < 4; w++) m_v[t[1:0]][t[9:2]][w] = 0;
         end
      m_rnd = {m_rnd[6:0], m_rnd[7] ^ m_rnd[5] ^ m_rnd[4] ^ m_rnd[3]};
   endfunction

   // Drive at negedge, compare comb outputs, then apply the edge to the model
   task automatic step(input bit r, input bit fv, input bit [27:0] fa, input bit [23:0] fd,
                       input bit sw, input bit [27:0] sa, input bit [27:0] la, input string req);
      bit eh; bit [23:0] ed;
      rst = r; fill_valid = fv; fill_addr = fa; fill_data = fd;
      snoop_we = sw; snoop_addr = sa; lookup_addr = la;
      #1;
      if (!r) begin
         m_lookup(la, eh, ed);
         checks++;
         if (hit !== eh || instr !== ed) begin
            errors++;
            $display("FAIL %s addr=%h actual hit=%b data=%h expected hit=%b data=%h",
                     req, la, hit, instr, eh, ed);
         end
      end
      @(posedge clk);
      m_edge(r, fv, fa, fd, sw, sa);
      @(negedge clk);
   endtask

   task automatic look(input bit [27:0] la, input string req);
      step(0, 0, 0, 0, 0, 0, la, req);
   endtask

   task automatic fill(input bit [27:0] fa, input bit [23:0] fd, input bit [27:0] la, input string req);
      step(0, 1, fa, fd, 0, 0, la, req);
   endtask

   task automatic snoop(input bit [27:0] sa, input string req);
      step(0, 0, 0, 0, 1, sa, sa, req);
   endtask

   initial begin
      rst = 1; fill_valid = 0; snoop_we = 0; fill_addr = 0; fill_data = 0;
      snoop_addr = 0; lookup_addr = 0;
      @(negedge clk);
      repeat (3) step(1, 0, 0, 0, 0, 0, 0, "R9");

      // R9 / R2: empty after reset
      look(28'h0000123, "R9");
      look(28'h0000000, "R2");

      // R1 / R10: lookup in the fill cycle misses, next cycle hits
      fill(28'h0000123, 24'hA1B2C3, 28'h0000123, "R10");
      look(28'h0000123, "R1");
      look(28'h0000127, "R2");

      // R3 / R4 / R5: five tags into one set exercise the random victim
      for (int t = 0; t < 5; t++) fill({18'(t + 1), 10'h040}, 24'(32'h100 * t + 7), 28'h0, "R4");
      for (int t = 0; t < 5; t++) look({18'(t + 1), 10'h040}, "R3");
      for (int t = 0; t < 5; t++) look({18'(t + 1), 10'h040}, "R5");

      // R4: refill of a resident tag overwrites in place
      fill(28'h0000123, 24'h555555, 28'h0, "R4");
      fill(28'h0000123, 24'h666666, 28'h0, "R4");
      look(28'h0000123, "R4");

      // R6: snoop clears all tags in the targeted sets
      fill(28'h0000524, 24'h010203, 28'h0, "R6");
      fill(28'h0000125, 24'h0A0B0C, 28'h0, "R6");
      snoop(28'h0000125, "R6");
      look(28'h0000123, "R6");
      look(28'h0000524, "R6");
      look(28'h0000125, "R6");

      // R7: borrow into the previous set and 28-bit wrap at zero
      fill(28'h0000203, 24'h111111, 28'h0, "R7");
      fill(28'h0000202, 24'h222222, 28'h0, "R7");
      fill(28'h0000201, 24'h333333, 28'h0, "R7");
      snoop(28'h0000204, "R7");
      look(28'h0000203, "R7");
      look(28'h0000202, "R7");
      look(28'h0000201, "R7");
      fill(28'hFFFFFFF, 24'h444444, 28'h0, "R7");
      fill(28'hFFFFFFE, 24'h454545, 28'h0, "R7");
      fill(28'hFFFFFFD, 24'h464646, 28'h0, "R7");
      snoop(28'h0000000, "R7");
      look(28'hFFFFFFF, "R7");
      look(28'hFFFFFFE, "R7");
      look(28'hFFFFFFD, "R7");

      // R8: fill and colliding snoop in the same cycle
      step(0, 1, 28'h0000300, 24'h777777, 1, 28'h0000302, 28'h0000300, "R8");
      look(28'h0000300, "R8");
      step(0, 1, 28'h0000310, 24'h787878, 1, 28'h0000302, 28'h0000310, "R8");
      look(28'h0000310, "R8");

      // Random mix over a few sets and tags, compared every clock
      void'($urandom(32'd7));
      for (int i = 0; i < 3000; i++) begin
         bit [27:0] fa = {18'($urandom % 6), 10'($urandom % 12)};
         bit [27:0] sa = {18'($urandom % 6), 10'($urandom % 12)};
         bit [27:0] la = {18'($urandom % 6), 10'($urandom % 12)};
         step(0, ($urandom % 3) != 0, fa, 24'($urandom), ($urandom % 8) == 0, sa, la, "R4");
      end

      // R9: reset in mid-run empties everything
      fill(28'h0000123, 24'h999999, 28'h0, "R9");
      step(1, 0, 0, 0, 0, 0, 0, "R9");
      look(28'h0000123, "R9");
      look(28'h0000004, "R9");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule